// File: doc/BRIEF.md
# Guarded Control Bus Write Filter

This block sits between an 8-bit control bus and a 32-entry register file with 5-bit addresses, and it decides whether each write cycle is applied. A write is sampled on the bus in one cycle and judged in the next. In that second cycle the block checks the bus parity when checking is switched on by a pin. It refuses any write aimed at a read-only address. For four status registers, it lets the write through only when the register's present contents equal the value software last copied into a paired compare register. This stops a read-modify-write sequence from wiping status bits that arrived after software last read the register.

Each outcome produces a single-cycle event pulse for the interrupt logic: parity error, write reject or conditional write inhibit. An inhibit also sets a sticky flag bit, which stays set until software writes it clear. Reads are combinational from the register file and never raise an event. The individual status registers are modelled as plain storage.

The controller has two states. ST_IDLE waits for a write strobe. ST_EVAL judges the write captured on the previous edge and commits it or raises one event. The transitions are IDLE->EVAL on a write strobe, EVAL->EVAL when another strobe arrives while judging, and EVAL->IDLE when no strobe arrives.

Top module: `cbus_write_guard`

## Requirements
- R1: After reset every register reads 00h and all three event outputs are low.
- R2: A write with good parity to an address that is neither read-only nor guarded is stored, and the new value reads back once the evaluation cycle is over. No event is raised.
- R3: A write to any of 08h, 0Fh, 10h, 13h, 14h, 16h, 18h, 19h, 1Eh or 1Fh leaves that register unchanged and raises evt_reject.
- R4: Parity is odd over wdata plus wpar. When par_chk_en is high during the write cycle and parity fails, the block raises evt_par_err and changes no register.
- R5: When par_chk_en is low, a write with bad parity is handled as if its parity were good.
- R6: The guarded pairs are 02h with 1Ah, 04h with 1Bh, 09h with 1Ch and 0Ah with 1Dh. A write to a guarded register whose contents equal its compare register stores the full data, and the compare register stays unchanged.
- R7: When a guarded register differs from its compare register, the write leaves the register unchanged, raises evt_inhibit, and sets bit 3 of register 02h.
- R8: Bit 3 of register 02h stays set until an accepted write to 02h clears it.
- R9: Each event is a one-cycle pulse in the cycle after the write strobe is sampled. No event appears unless a write was sampled on the previous edge.
- R10: At most one event fires per write. Parity error takes priority over reject, and reject over inhibit.
- R11: Writes on consecutive cycles are each evaluated. A later write sees the effect of the earlier one.
- R12: Changing the address without a write strobe raises no event and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_chk_en | input | 1 | Enables parity checking of write data |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| wpar | input | 1 | Odd parity bit for wdata |
| rdata | output | 8 | Combinational read data at addr |
| evt_par_err | output | 1 | Parity error event pulse |
| evt_reject | output | 1 | Read-only write reject event pulse |
| evt_inhibit | output | 1 | Conditional write inhibit event pulse |

## Verification
A write strobe sampled on edge k puts its event on the outputs between edge k and edge k+1. The write itself lands on edge k+1, so a read-back is valid from the falling edge after k+1. The driver tags each expected event set with the cycle number that follows the sampling edge. The monitor compares the event outputs at the falling edge of exactly that cycle, and it expects all three outputs low on every other falling edge. Read-back checks wait at least one idle cycle after the write's evaluation cycle before setting the address and sampling rdata.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_EVAL} cbg_state_t;

    function automatic logic addr_is_ro(input logic [4:0] a);
        case (a)
            5'h08, 5'h0F, 5'h10, 5'h13, 5'h14,
            5'h16, 5'h18, 5'h19, 5'h1E, 5'h1F: addr_is_ro = 1'b1;
            default:                           addr_is_ro = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cbg_parity.sv
module cbg_parity #(
    parameter int DATA_W = 8
) (
    input  logic              chk_en,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              ok
);
    logic odd_ones;
    assign odd_ones = ^{data, par};
    assign ok = !chk_en || odd_ones;
endmodule

// File: rtl/cbg_addr_class.sv
module cbg_addr_class #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ro,
    output logic              is_guard,
    output logic [ADDR_W-1:0] cmp_addr
);
    always_comb begin
        is_ro    = cbg_pkg::addr_is_ro(addr);
        is_guard = 1'b1;
        cmp_addr = '0;
        unique case (addr)
            ADDR_W'(5'h02): cmp_addr = ADDR_W'(5'h1A);
            ADDR_W'(5'h04): cmp_addr = ADDR_W'(5'h1B);
            ADDR_W'(5'h09): cmp_addr = ADDR_W'(5'h1C);
            ADDR_W'(5'h0A): cmp_addr = ADDR_W'(5'h1D);
            default:        is_guard = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbg_regfile.sv
module cbg_regfile #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int FLAG_REG = 2,
    parameter int FLAG_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag_set,
    input  logic [ADDR_W-1:0] ra_bus,
    output logic [DATA_W-1:0] rd_bus,
    input  logic [ADDR_W-1:0] ra_cur,
    output logic [DATA_W-1:0] rd_cur,
    input  logic [ADDR_W-1:0] ra_cmp,
    output logic [DATA_W-1:0] rd_cmp
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == FLAG_REG) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (we && waddr == ADDR_W'(i))
                    mem[i] <= wdata;
                else if (flag_set)
                    mem[i][FLAG_BIT] <= 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (we && waddr == ADDR_W'(i))
                    mem[i] <= wdata;
            end
        end
    end

    assign rd_bus = mem[ra_bus];
    assign rd_cur = mem[ra_cur];
    assign rd_cmp = mem[ra_cmp];

    // R8: the flag is cleared only by a write to its register
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[FLAG_REG][FLAG_BIT] && !(we && waddr == ADDR_W'(FLAG_REG)))
            |=> mem[FLAG_REG][FLAG_BIT]);

    // R3: the commit port never targets a read-only address
    p_no_ro_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !(waddr inside {5'h08, 5'h0F, 5'h10, 5'h13, 5'h14,
                               5'h16, 5'h18, 5'h19, 5'h1E, 5'h1F}));
endmodule

// File: rtl/cbus_write_guard.sv
module cbus_write_guard #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int FLAG_REG = 2,
    parameter int FLAG_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_chk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wpar,
    output logic [DATA_W-1:0] rdata,
    output logic              evt_par_err,
    output logic              evt_reject,
    output logic              evt_inhibit
);
    import cbg_pkg::*;

    cbg_state_t        state_q, state_d;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_data;
    logic              q_par_ok;
    logic              par_ok;
    logic              q_ro, q_guard;
    logic [ADDR_W-1:0] q_cmp_addr;
    logic [DATA_W-1:0] cur_val, cmp_val;
    logic              commit, flag_set;

    cbg_parity #(.DATA_W(DATA_W)) u_par (
        .chk_en (par_chk_en),
        .data   (wdata),
        .par    (wpar),
        .ok     (par_ok)
    );

    cbg_addr_class #(.ADDR_W(ADDR_W)) u_cls (
        .addr     (q_addr),
        .is_ro    (q_ro),
        .is_guard (q_guard),
        .cmp_addr (q_cmp_addr)
    );

    cbg_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .FLAG_REG(FLAG_REG), .FLAG_BIT(FLAG_BIT)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit),
        .waddr    (q_addr),
        .wdata    (q_data),
        .flag_set (flag_set),
        .ra_bus   (addr),
        .rd_bus   (rdata),
        .ra_cur   (q_addr),
        .rd_cur   (cur_val),
        .ra_cmp   (q_cmp_addr),
        .rd_cmp   (cmp_val)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_en) state_d = ST_EVAL;
            ST_EVAL: state_d = wr_en ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and write capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            q_addr   <= '0;
            q_data   <= '0;
            q_par_ok <= 1'b1;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                q_addr   <= addr;
                q_data   <= wdata;
                q_par_ok <= par_ok;
            end
        end
    end

    // outputs: verdict on the captured write
    always_comb begin
        evt_par_err = 1'b0;
        evt_reject  = 1'b0;
        evt_inhibit = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EVAL: begin
                if (!q_par_ok)
                    evt_par_err = 1'b1;
                else if (q_ro)
                    evt_reject = 1'b1;
                else if (q_guard && cur_val != cmp_val)
                    evt_inhibit = 1'b1;
                else
                    commit = 1'b1;
            end
            default: ;
        endcase
        flag_set = evt_inhibit;
    end

    // R10: a write yields at most one event
    p_evt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_par_err, evt_reject, evt_inhibit}));

    // R9: no event without a write sampled on the previous edge
    p_quiet_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !(evt_par_err || evt_reject || evt_inhibit));

    // R4: a parity failure with checking on is reported next cycle
    p_par_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && par_chk_en && !(^{wdata, wpar})) |=> evt_par_err);

    // R5: with checking off no parity event follows
    p_par_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !par_chk_en) |=> !evt_par_err);
endmodule

// File: tb/cbus_write_guard_tb.sv
module cbus_write_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_chk_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wpar = 1'b0;
    logic [7:0] rdata;
    logic       evt_par_err, evt_reject, evt_inhibit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int       due;
        logic [2:0] ev;
        string    tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cbus_write_guard dut_i (
        .clk(clk), .rst_n(rst_n), .par_chk_en(par_chk_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .wpar(wpar), .rdata(rdata),
        .evt_par_err(evt_par_err), .evt_reject(evt_reject),
        .evt_inhibit(evt_inhibit)
    );

    // monitor: events in order {par_err, reject, inhibit}
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({evt_par_err, evt_reject, evt_inhibit} !== e.ev) begin
                    errors++;
                    $display("FAIL %s events actual=%b expected=%b", e.tag,
                             {evt_par_err, evt_reject, evt_inhibit}, e.ev);
                end
            end else if (evt_par_err || evt_reject || evt_inhibit) begin
                checks++;
                errors++;
                $display("FAIL R9 stray event actual=%b expected=000",
                         {evt_par_err, evt_reject, evt_inhibit});
            end
        end
    end

    // driver: called at a falling edge, returns at the next falling edge
    task automatic do_write(input logic [4:0] a, input logic [7:0] d,
                            input bit bad_par, input logic [2:0] ev,
                            input string tag);
        exp_t e;
        addr  = a;
        wdata = d;
        wpar  = bad_par ? ^d : ~^d;
        wr_en = 1'b1;
        e.due = cyc + 1;
        e.ev  = ev;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_rd(input logic [4:0] a, input logic [7:0] exp,
                            input string tag);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h actual=%h expected=%h", tag, a, rdata, exp);
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check_rd(5'h00, 8'h00, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_rd(5'h08, 8'h00, "R1");
        check_rd(5'h02, 8'h00, "R1");
        checks++;
        if (evt_par_err || evt_reject || evt_inhibit) begin
            errors++;
            $display("FAIL R1 events actual=%b expected=000",
                     {evt_par_err, evt_reject, evt_inhibit});
        end

        // R2 plain write
        do_write(5'h05, 8'hA5, 0, 3'b000, "R2");
        idle(1);
        check_rd(5'h05, 8'hA5, "R2");

        // R3 read-only addresses
        do_write(5'h08, 8'hFF, 0, 3'b010, "R3");
        do_write(5'h1F, 8'h3C, 0, 3'b010, "R3");
        do_write(5'h13, 8'h81, 0, 3'b010, "R3");
        idle(1);
        check_rd(5'h08, 8'h00, "R3");
        check_rd(5'h1F, 8'h00, "R3");
        check_rd(5'h13, 8'h00, "R3");

        // R4 parity error discards write
        par_chk_en = 1'b1;
        do_write(5'h06, 8'h77, 1, 3'b100, "R4");
        idle(1);
        check_rd(5'h06, 8'h00, "R4");
        // R10 parity beats reject
        do_write(5'h08, 8'h12, 1, 3'b100, "R10");
        // R10 parity beats inhibit is covered below once a mismatch exists
        idle(1);

        // R5 checking off
        par_chk_en = 1'b0;
        do_write(5'h06, 8'h77, 1, 3'b000, "R5");
        idle(1);
        check_rd(5'h06, 8'h77, "R5");

        // R6 guarded write with match
        par_chk_en = 1'b1;
        do_write(5'h04, 8'h55, 0, 3'b000, "R6");
        idle(1);
        check_rd(5'h04, 8'h55, "R6");
        check_rd(5'h1B, 8'h00, "R6");

        // R7 mismatch inhibits
        do_write(5'h04, 8'h11, 0, 3'b001, "R7");
        idle(1);
        check_rd(5'h04, 8'h55, "R7");
        check_rd(5'h02, 8'h08, "R7");
        do_write(5'h04, 8'h11, 1, 3'b100, "R10");
        idle(1);
        check_rd(5'h04, 8'h55, "R10");

        // R8 sticky flag
        idle(5);
        check_rd(5'h02, 8'h08, "R8");
        do_write(5'h1A, 8'h08, 0, 3'b000, "R8");
        do_write(5'h02, 8'h00, 0, 3'b000, "R8");
        idle(1);
        check_rd(5'h02, 8'h00, "R8");

        // R6 after compare reload
        do_write(5'h1B, 8'h55, 0, 3'b000, "R6");
        do_write(5'h04, 8'h11, 0, 3'b000, "R6");
        idle(1);
        check_rd(5'h04, 8'h11, "R6");
        check_rd(5'h1B, 8'h55, "R6");

        // R11 back-to-back writes
        do_write(5'h0A, 8'h01, 0, 3'b000, "R11");
        do_write(5'h0A, 8'h02, 0, 3'b001, "R11");
        do_write(5'h0C, 8'h09, 0, 3'b000, "R11");
        idle(1);
        check_rd(5'h0A, 8'h01, "R11");
        check_rd(5'h0C, 8'h09, "R11");
        check_rd(5'h02, 8'h08, "R11");

        // R12 address changes without strobe
        for (int i = 0; i < 32; i++) begin
            addr = 5'(i);
            wdata = 8'(i * 7);
            @(negedge clk);
        end
        check_rd(5'h02, 8'h08, "R12");
        check_rd(5'h0C, 8'h09, "R12");
        check_rd(5'h05, 8'hA5, "R12");

        idle(2);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R9 pending actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule